// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers 32 level-sensitive interrupt request lines into one request toward a parent interrupt controller. Every source has an enable bit. A source counts as pending while its input is high and its enable bit is set. The single parent request is high whenever at least one source is pending.

Software reaches the block through a plain register bus with valid, write, byte address, write data and read data. Enables are never written as a whole word. One register sets the enable bits marked by ones in the written word. A second register clears the enable bits marked by ones. A third register clears every enable at once, whatever data is written. Reading the pending register returns the live AND of the inputs and the enables. A handler reads that word, services the sources it shows, and reads again until the word is zero.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every enable bit is 0, so a read of the pending register returns 0 and `irq_out` is 0, even with all inputs high.
- R2: A write to byte address 0x10 sets enable bit n for every bit n that is 1 in the written word; enable bits whose written bit is 0 keep their value.
- R3: A write to byte address 0x0C clears enable bit n for every bit n that is 1 in the written word; enable bits whose written bit is 0 keep their value.
- R4: A write to byte address 0x08 clears all 32 enable bits, whatever the written data (including all zeros).
- R5: A read (valid high, write low) at byte address 0x04 returns, in the same cycle, a word whose bit n is input n ANDed with enable bit n.
- R6: Pending bits are not latched: when an enabled input falls, its bit in the pending read is 0 at once, with no clock edge and no software action.
- R7: `irq_out` is a register that, on each clock edge, takes the OR of all pending bits as they were just before that edge.
- R8: `bus_rdata` is 0 whenever the bus does not present a read of 0x04: for reads at any other address, during writes, and while valid is low.
- R9: Writes to any address other than 0x08, 0x0C and 0x10 (0x04 included), and bus cycles with valid low, leave every enable bit unchanged.
- R10: An enable write takes effect at the clock edge that accepts it. A pending read after that edge shows the new enables. `irq_out` follows one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_src | input | 32 | Level-sensitive request lines, bit n is source n |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Registered combined request to the parent controller |

## Verification
The bench checks that zero bits in the set and clear words leave their enables unchanged; a design that wrote the word straight into the mask would wipe out unrelated enables. It writes zero to the disable-all address to catch a design that uses the data there as a mask. It drops an enabled input and reads again without a clock edge to expose a latched pending bit. It also checks `irq_out` in the cycle between the enable write and the edge after it, which shows whether the output register is missing or doubled.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

    // Byte offsets of the register window
    localparam int unsigned OFS_PENDING = 32'h04;
    localparam int unsigned OFS_KILLALL = 32'h08;
    localparam int unsigned OFS_ENCLR   = 32'h0C;
    localparam int unsigned OFS_ENSET   = 32'h10;

    localparam int unsigned MAX_SRC = 32;

    typedef struct packed {
        logic [MAX_SRC-1:0] en;
    } mask_state_t;

    typedef struct packed {
        logic req;
    } req_state_t;

endpackage

// File: rtl/irqa_decode.sv
module irqa_decode #(
    parameter int unsigned AW = 8
) (
    input  logic          valid_i,
    input  logic          write_i,
    input  logic [AW-1:0] addr_i,
    output logic          rd_pend_o,
    output logic          wr_set_o,
    output logic          wr_clr_o,
    output logic          wr_kill_o
);
    import irqa_pkg::*;

    logic is_wr;
    logic is_rd;

    always_comb begin
        is_wr     = valid_i && write_i;
        is_rd     = valid_i && !write_i;
        rd_pend_o = is_rd && (addr_i == AW'(OFS_PENDING));
        wr_set_o  = is_wr && (addr_i == AW'(OFS_ENSET));
        wr_clr_o  = is_wr && (addr_i == AW'(OFS_ENCLR));
        wr_kill_o = is_wr && (addr_i == AW'(OFS_KILLALL));
    end

endmodule

// File: rtl/irqa_mask.sv
module irqa_mask #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_i,
    input  logic            clr_i,
    input  logic            kill_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] en_o
);
    import irqa_pkg::*;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            if (set_i && wdata_i[i]) st_d.en[i] = 1'b1;
            if (clr_i && wdata_i[i]) st_d.en[i] = 1'b0;
        end
        // clearing everything wins over any per-bit update
        if (kill_i) st_d.en = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign en_o = st_q.en[NSRC-1:0];

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        set_i && !kill_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));

    assert_setkeep_R2: assert property (@(posedge clk) disable iff (rst)
        set_i && !kill_i |=> ((en_o & ~$past(wdata_i)) == ($past(en_o) & ~$past(wdata_i))));

    assert_clr_R3: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> ((en_o & $past(wdata_i)) == '0));

    assert_clrkeep_R3: assert property (@(posedge clk) disable iff (rst)
        clr_i && !kill_i |=> ((en_o & ~$past(wdata_i)) == ($past(en_o) & ~$past(wdata_i))));

    assert_kill_R4: assert property (@(posedge clk) disable iff (rst)
        kill_i |=> (en_o == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(set_i || clr_i || kill_i) |=> $stable(en_o));

endmodule

// File: rtl/irqa_combine.sv
module irqa_combine #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] en_i,
    output logic [NSRC-1:0] pend_o,
    output logic            req_o
);
    import irqa_pkg::*;

    req_state_t r_d, r_q;

    always_comb begin
        pend_o  = src_i & en_i;
        r_d.req = |pend_o;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign req_o = r_q.req;

    assert_req_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (req_o == |($past(src_i) & $past(en_i))));

    assert_pendsub_R6: assert property (@(posedge clk) disable iff (rst)
        ((pend_o & ~src_i) == '0) && ((pend_o & ~en_i) == '0));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned AW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_src,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            irq_out
);
    import irqa_pkg::*;

    logic            rd_pend, wr_set, wr_clr, wr_kill;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pend;

    irqa_decode #(.AW(AW)) u_dec (
        .valid_i   (bus_valid),
        .write_i   (bus_write),
        .addr_i    (bus_addr),
        .rd_pend_o (rd_pend),
        .wr_set_o  (wr_set),
        .wr_clr_o  (wr_clr),
        .wr_kill_o (wr_kill)
    );

    irqa_mask #(.NSRC(NSRC)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_i   (wr_set),
        .clr_i   (wr_clr),
        .kill_i  (wr_kill),
        .wdata_i (bus_wdata),
        .en_o    (en_q)
    );

    irqa_combine #(.NSRC(NSRC)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .src_i  (irq_src),
        .en_i   (en_q),
        .pend_o (pend),
        .req_o  (irq_out)
    );

    assign bus_rdata = rd_pend ? pend : '0;

    assert_rdzero_R8: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write && bus_addr == AW'(OFS_PENDING)) |-> (bus_rdata == '0));

    assert_rdpend_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == AW'(OFS_PENDING)) |-> ((bus_rdata & ~irq_src) == '0));

    assert_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_pend, wr_set, wr_clr, wr_kill}));

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_src;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] model_en;

    always #2.5 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst(rst), .irq_src(irq_src),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] src;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 32'h0000_00FF, 32'hFFFF_FFFF},
        '{8'h10, 32'h8000_0000, 32'hFFFF_FFFF},
        '{8'h0C, 32'h0000_000F, 32'hFFFF_FFFF},
        '{8'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        '{8'h00, 32'hFFFF_FFFF, 32'h0000_0010},
        '{8'h08, 32'h0000_0000, 32'hFFFF_FFFF},
        '{8'h10, 32'hAAAA_5555, 32'h0F0F_0F0F},
        '{8'h0C, 32'hFFFF_0000, 32'hF0F0_FFFF},
        '{8'h10, 32'h0000_0000, 32'hFFFF_FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] apply(input logic [31:0] en, input logic [7:0] a,
                                          input logic [31:0] d);
        case (a)
            8'h10:   return en | d;
            8'h0C:   return en & ~d;
            8'h08:   return 32'h0;
            default: return en;
        endcase
    endfunction

    // write; returns at the falling edge after the accepting rising edge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_valid = 1'b0;
        #0.5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; irq_src = '1; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
        model_en = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        bus_rd(8'h04, 32'h0, "R1 pending after reset");
        check("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);

        // table walk: R2 R3 R4 R5 R7 R9
        for (int i = 0; i < NV; i++) begin
            irq_src = VECS[i].src;
            if (VECS[i].addr == 8'h00) @(negedge clk);
            else bus_wr(VECS[i].addr, VECS[i].data);
            model_en = apply(model_en, VECS[i].addr, VECS[i].data);
            bus_rd(8'h04, model_en & irq_src, $sformatf("R2/R3/R4/R5/R9 vec %0d pending", i));
            @(negedge clk);
            check($sformatf("R7 vec %0d irq_out", i), {31'b0, irq_out},
                  {31'b0, |(model_en & irq_src)});
        end

        // R6: level not latched, no clock edge between
        bus_wr(8'h08, 32'hFFFF_FFFF);
        bus_wr(8'h10, 32'h0000_0300);
        irq_src = 32'h0000_0300;
        bus_rd(8'h04, 32'h0000_0300, "R6 pending with input high");
        irq_src = 32'h0000_0100;
        bus_rd(8'h04, 32'h0000_0100, "R6 pending drops with input");

        // R8: reads elsewhere, and writes, return zero
        bus_rd(8'h08, 32'h0, "R8 read at 0x08");
        bus_rd(8'h10, 32'h0, "R8 read at 0x10");
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0;
        #1;
        check("R8 rdata during write at 0x04", bus_rdata, 32'h0);
        bus_valid = 1'b0; bus_write = 1'b0;
        bus_addr = 8'h04;
        #1;
        check("R8 rdata with valid low", bus_rdata, 32'h0);

        // R9: write to pending address and invalid write are ignored
        irq_src = '1;
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_rd(8'h04, 32'h0000_0300, "R9 write to 0x04 ignored");
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 8'h10; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_write = 1'b0; bus_wdata = '0;
        bus_rd(8'h04, 32'h0000_0300, "R9 invalid write ignored");

        // R4: kill with zero data, R10: timing of irq_out
        bus_wr(8'h08, 32'h0);
        bus_rd(8'h04, 32'h0, "R4 kill with zero data");
        check("R10 irq_out still high one edge after kill", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R10 irq_out low after next edge", {31'b0, irq_out}, 32'h0);
        bus_wr(8'h10, 32'h0001_0000);
        bus_rd(8'h04, 32'h0001_0000, "R10 pending right after set");
        check("R10 irq_out not yet high", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R10 irq_out high one edge later", {31'b0, irq_out}, 32'h1);

        // R1 again: reset mid-run clears enables
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_rd(8'h04, 32'h0, "R1 pending after second reset");
        check("R1 irq_out after second reset", {31'b0, irq_out}, 32'h0);

        finish_run();
    end

endmodule